// File: doc/BRIEF.md
# Console Keyboard and Display Register Bank

This block is a peripheral register bank that sits on the load/store path of a 16-bit processor. It owns the top of the address space, from 0xFE00 upward. Any access in that window goes to the block rather than to general memory. The window holds five registers:

- keyboard status (0xFE00)
- keyboard character (0xFE02)
- display status (0xFE04)
- display character (0xFE06)
- machine control (0xFFFE)

A keyboard source pushes characters in with a one-cycle strobe. A display sink pulls characters out through a valid/ready handshake.

Software works the devices by polling or by interrupts. Each status register has a flag in bit 15 and an interrupt enable in bit 14. The flags change as side effects of bus traffic. Reading the keyboard character clears the keyboard flag. Writing the display character clears the display flag until the sink takes the character. Each device drives an interrupt request while its flag and its enable are both 1. Bit 15 of the machine control register is a run latch that lets the processor execute. Writing 0 to it halts the processor.

Top module: `console_io_regs`

## Requirements
- R1: After reset the keyboard flag is 0, the display flag is 1, the run latch is 1 and both interrupt enables are 0. Reads return 0x0000 at 0xFE00, 0x8000 at 0xFE04 and 0x8000 at 0xFFFE.
- R2: Reads return fixed layouts. The keyboard and display status registers return flag in bit 15, enable in bit 14 and zeros elsewhere. The two character registers return the character in bits 7:0 with zeros above. The machine control register returns the run latch in bit 15 with zeros elsewhere. Any other address in the window reads 0x0000.
- R3: A cycle with key_valid high loads key_char into the keyboard character register and sets the keyboard flag on that clock edge.
- R4: A read of 0xFE02 clears the keyboard flag on that edge. If a key arrives in the same cycle, the new key wins: the flag stays 1 and the character is replaced. The read itself still returns the old character.
- R5: A key that arrives while the flag is already 1 overwrites the character, and the flag stays 1.
- R6: Writes to 0xFE02 have no effect. A write to 0xFE00 changes only the enable from bit 14 and leaves the flag alone.
- R7: A write to 0xFE06 stores bits 7:0 and clears the display flag. While the flag is 0, disp_valid is high and disp_char stays steady.
- R8: A cycle with disp_valid and disp_ready both high sets the display flag on that edge, and disp_valid then falls. A write to 0xFE06 in that same cycle wins.
- R9: kbd_irq equals keyboard flag AND keyboard enable. disp_irq equals display flag AND display enable. A write to 0xFE04 changes only the display enable.
- R10: A write to 0xFFFE loads bit 15 into the run latch, and run_en follows the latch.
- R11: bus_hit is 1 exactly when bus_addr is 0xFE00 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor access address |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data (combinational) |
| bus_hit | output | 1 | Address lies in the device window |
| key_valid | input | 1 | New key strobe from keyboard source |
| key_char | input | 8 | Key code |
| disp_valid | output | 1 | Character waiting for the display sink |
| disp_ready | input | 1 | Display sink accepts |
| disp_char | output | 8 | Character for the display sink |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |
| run_en | output | 1 | Run latch output |

## Verification
Load data and bus_hit are combinational. They are due in the same cycle as the address, so the bench samples them 1 ns after it drives inputs on the falling edge, before the next rising edge. Flag, character, handshake and run-latch effects are due on the first rising edge after the stimulus. The interrupt outputs follow them with no added delay in the default variant. The bench therefore checks those results on the following falling edge, or through a load issued afterwards.

// File: rtl/console_io_pkg.sv
package console_io_pkg;
   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_KSTAT = 3'd1,
      SEL_KCHAR = 3'd2,
      SEL_DSTAT = 3'd3,
      SEL_DCHAR = 3'd4,
      SEL_MCTL  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
   import console_io_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]    WIN_BASE = 16'hFE00,
   parameter logic [ADDR_W-1:0]    A_KSTAT  = 16'hFE00,
   parameter logic [ADDR_W-1:0]    A_KCHAR  = 16'hFE02,
   parameter logic [ADDR_W-1:0]    A_DSTAT  = 16'hFE04,
   parameter logic [ADDR_W-1:0]    A_DCHAR  = 16'hFE06,
   parameter logic [ADDR_W-1:0]    A_MCTL   = 16'hFFFE
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              hit,
   output reg_sel_e          sel,
   output logic              rd_kchar,
   output logic              wr_kstat,
   output logic              wr_dstat,
   output logic              wr_dchar,
   output logic              wr_mctl
);
   always_comb begin
      hit = (addr >= WIN_BASE);
      sel = SEL_NONE;
      if (hit) begin
         if      (addr == A_KSTAT) sel = SEL_KSTAT;
         else if (addr == A_KCHAR) sel = SEL_KCHAR;
         else if (addr == A_DSTAT) sel = SEL_DSTAT;
         else if (addr == A_DCHAR) sel = SEL_DCHAR;
         else if (addr == A_MCTL)  sel = SEL_MCTL;
      end
   end

   assign rd_kchar = rd && (sel == SEL_KCHAR);
   assign wr_kstat = wr && (sel == SEL_KSTAT);
   assign wr_dstat = wr && (sel == SEL_DSTAT);
   assign wr_dchar = wr && (sel == SEL_DCHAR);
   assign wr_mctl  = wr && (sel == SEL_MCTL);
endmodule

// File: rtl/cio_kbd_chan.sv
module cio_kbd_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_char,
   input  logic              stat_wr,
   input  logic              ie_wval,
   input  logic              char_rd,
   output logic              ready,
   output logic              ie,
   output logic [CHAR_W-1:0] char_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b0;
         ie     <= 1'b0;
         char_q <= '0;
      end else begin
         if (stat_wr) ie <= ie_wval;
         if (key_valid) begin
            char_q <= key_char;
            ready  <= 1'b1;
         end else if (char_rd) begin
            ready  <= 1'b0;
         end
      end
   end

   p_key_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> (ready && char_q == $past(key_char)));
   p_read_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_rd && !key_valid) |=> !ready);
   p_stat_write_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !key_valid && !char_rd) |=> $stable(ready));
endmodule

// File: rtl/cio_disp_chan.sv
module cio_disp_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_wr,
   input  logic [CHAR_W-1:0] char_wval,
   input  logic              stat_wr,
   input  logic              ie_wval,
   input  logic              sink_ready,
   output logic              done,
   output logic              ie,
   output logic              valid,
   output logic [CHAR_W-1:0] char_q
);
   assign valid = !done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done   <= 1'b1;
         ie     <= 1'b0;
         char_q <= '0;
      end else begin
         if (stat_wr) ie <= ie_wval;
         if (char_wr) begin
            char_q <= char_wval;
            done   <= 1'b0;
         end else if (valid && sink_ready) begin
            done   <= 1'b1;
         end
      end
   end

   p_write_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      char_wr |=> (!done && char_q == $past(char_wval)));
   p_hold_until_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !sink_ready && !char_wr) |=> (valid && $stable(char_q)));
   p_accept_sets_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sink_ready && !char_wr) |=> done);
endmodule

// File: rtl/cio_run_latch.sv
module cio_run_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wval,
   output logic run
);
   always_ff @(posedge clk) begin
      if (!rst_n)  run <= 1'b1;
      else if (wr) run <= wval;
   end

   p_run_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (run == $past(wval)));
   p_run_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(run));
endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
   import console_io_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 16,
   parameter int unsigned          DATA_W   = 16,
   parameter int unsigned          CHAR_W   = 8,
   parameter logic [ADDR_W-1:0]    WIN_BASE = 16'hFE00,
   parameter logic [ADDR_W-1:0]    A_KSTAT  = 16'hFE00,
   parameter logic [ADDR_W-1:0]    A_KCHAR  = 16'hFE02,
   parameter logic [ADDR_W-1:0]    A_DSTAT  = 16'hFE04,
   parameter logic [ADDR_W-1:0]    A_DCHAR  = 16'hFE06,
   parameter logic [ADDR_W-1:0]    A_MCTL   = 16'hFFFE,
   parameter bit                   IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_hit,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_char,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [CHAR_W-1:0] disp_char,
   output logic              kbd_irq,
   output logic              disp_irq,
   output logic              run_en
);
   localparam int unsigned FLAG_BIT = DATA_W - 1;
   localparam int unsigned IE_BIT   = DATA_W - 2;

   if (CHAR_W + 2 > DATA_W) begin : g_bad_width
      $error("console_io_regs: CHAR_W must leave room for flag and enable bits");
   end
   if (WIN_BASE > A_KSTAT || WIN_BASE > A_KCHAR || WIN_BASE > A_DSTAT ||
       WIN_BASE > A_DCHAR || WIN_BASE > A_MCTL) begin : g_bad_map
      $error("console_io_regs: every register must sit inside the device window");
   end

   reg_sel_e          sel;
   logic              rd_kchar, wr_kstat, wr_dstat, wr_dchar, wr_mctl;
   logic              k_ready, k_ie, d_done, d_ie;
   logic [CHAR_W-1:0] k_char;
   logic              unused_wbits;

   assign unused_wbits = ^bus_wdata;

   cio_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .A_KSTAT(A_KSTAT), .A_KCHAR(A_KCHAR),
      .A_DSTAT(A_DSTAT), .A_DCHAR(A_DCHAR), .A_MCTL(A_MCTL)
   ) u_decode (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .hit(bus_hit), .sel(sel),
      .rd_kchar(rd_kchar), .wr_kstat(wr_kstat), .wr_dstat(wr_dstat),
      .wr_dchar(wr_dchar), .wr_mctl(wr_mctl)
   );

   cio_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
      .stat_wr(wr_kstat), .ie_wval(bus_wdata[IE_BIT]), .char_rd(rd_kchar),
      .ready(k_ready), .ie(k_ie), .char_q(k_char)
   );

   cio_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
      .clk(clk), .rst_n(rst_n), .char_wr(wr_dchar), .char_wval(bus_wdata[CHAR_W-1:0]),
      .stat_wr(wr_dstat), .ie_wval(bus_wdata[IE_BIT]), .sink_ready(disp_ready),
      .done(d_done), .ie(d_ie), .valid(disp_valid), .char_q(disp_char)
   );

   cio_run_latch u_run (
      .clk(clk), .rst_n(rst_n), .wr(wr_mctl), .wval(bus_wdata[FLAG_BIT]), .run(run_en)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_KSTAT: begin
            bus_rdata[FLAG_BIT] = k_ready;
            bus_rdata[IE_BIT]   = k_ie;
         end
         SEL_KCHAR: bus_rdata[CHAR_W-1:0] = k_char;
         SEL_DSTAT: begin
            bus_rdata[FLAG_BIT] = d_done;
            bus_rdata[IE_BIT]   = d_ie;
         end
         SEL_DCHAR: bus_rdata[CHAR_W-1:0] = disp_char;
         SEL_MCTL:  bus_rdata[FLAG_BIT]   = run_en;
         default:   bus_rdata = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kbd_irq  <= 1'b0;
            disp_irq <= 1'b0;
         end else begin
            kbd_irq  <= k_ready && k_ie;
            disp_irq <= d_done && d_ie;
         end
      end
   end else begin : g_irq_comb
      assign kbd_irq  = k_ready && k_ie;
      assign disp_irq = d_done && d_ie;
   end

   p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!k_ie && !d_ie && !wr_kstat && !wr_dstat) |=> (!kbd_irq && !disp_irq));
   p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_hit) |-> (bus_rdata == '0));
endmodule

// File: tb/console_io_regs_tb.sv
module console_io_regs_tb;
   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] data;
      logic [15:0] expv;
      logic [3:0]  req;
   } vec_t;

   // Register-access vectors walked after reset; the req field names the requirement (R1, R2, R6, R9).
   localparam vec_t VEC [0:12] = '{
      '{1'b0, 16'hFE00, 16'h0000, 16'h0000, 4'd1},  // R1 keyboard status after reset
      '{1'b0, 16'hFE04, 16'h0000, 16'h8000, 4'd1},  // R1 display status after reset
      '{1'b0, 16'hFFFE, 16'h0000, 16'h8000, 4'd1},  // R1 run latch after reset
      '{1'b1, 16'hFE00, 16'hFFFF, 16'h0000, 4'd6},  // R6 only enable may change
      '{1'b0, 16'hFE00, 16'h0000, 16'h4000, 4'd6},
      '{1'b1, 16'hFE02, 16'h00AA, 16'h0000, 4'd6},  // R6 write to key char ignored
      '{1'b0, 16'hFE02, 16'h0000, 16'h0000, 4'd6},
      '{1'b1, 16'hFE04, 16'h4000, 16'h0000, 4'd9},  // R9 display enable
      '{1'b0, 16'hFE04, 16'h0000, 16'hC000, 4'd2},  // R2 flag + enable layout
      '{1'b0, 16'hFE08, 16'h0000, 16'h0000, 4'd2},  // R2 unmapped in window
      '{1'b1, 16'hFE04, 16'h0000, 16'h0000, 4'd9},
      '{1'b0, 16'hFE04, 16'h0000, 16'h8000, 4'd9},
      '{1'b1, 16'hFE00, 16'h0000, 16'h0000, 4'd6}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_hit;
   logic        key_valid = 1'b0;
   logic [7:0]  key_char = '0;
   logic        disp_valid, disp_ready = 1'b0;
   logic [7:0]  disp_char;
   logic        kbd_irq, disp_irq, run_en;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   console_io_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
      .key_valid(key_valid), .key_char(key_char), .disp_valid(disp_valid),
      .disp_ready(disp_ready), .disp_char(disp_char), .kbd_irq(kbd_irq),
      .disp_irq(disp_irq), .run_en(run_en)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic bus_read(input logic [15:0] a, input logic [15:0] expv, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 check(bus_rdata, expv, tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic send_key(input logic [7:0] c);
      @(negedge clk);
      key_valid = 1'b1; key_char = c;
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   task automatic sink_take();
      @(negedge clk);
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check({15'd0, run_en}, 16'd1, "R1 run_en after reset");
      check({14'd0, disp_valid, kbd_irq}, 16'd0, "R1 idle outputs after reset");

      for (int i = 0; i < 13; i++) begin
         if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
         else bus_read(VEC[i].addr, VEC[i].expv, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end

      // R3 capture, R4 read clears flag
      send_key(8'h41);
      bus_read(16'hFE00, 16'h8000, "R3 flag set by key");
      bus_read(16'hFE02, 16'h0041, "R3 key char");
      bus_read(16'hFE00, 16'h0000, "R4 flag cleared by read");

      // R5 overwrite while flag set
      send_key(8'h31);
      send_key(8'h32);
      bus_read(16'hFE00, 16'h8000, "R5 flag stays set");
      bus_read(16'hFE02, 16'h0032, "R5 newer key kept");

      // R4 key in the same cycle as the read
      send_key(8'h33);
      @(negedge clk);
      bus_addr = 16'hFE02; bus_rd = 1'b1; key_valid = 1'b1; key_char = 8'h34;
      #1 check(bus_rdata, 16'h0033, "R4 read returns old char");
      @(negedge clk);
      bus_rd = 1'b0; key_valid = 1'b0;
      bus_read(16'hFE00, 16'h8000, "R4 same-cycle key keeps flag");
      bus_read(16'hFE02, 16'h0034, "R4 same-cycle key stored");

      // R9 keyboard interrupt
      bus_write(16'hFE00, 16'h4000);
      #1 check({15'd0, kbd_irq}, 16'd0, "R9 kbd_irq low without flag");
      send_key(8'h35);
      #1 check({15'd0, kbd_irq}, 16'd1, "R9 kbd_irq high");
      bus_read(16'hFE02, 16'h0035, "R9 char read");
      #1 check({15'd0, kbd_irq}, 16'd0, "R9 kbd_irq drops after read");
      bus_write(16'hFE00, 16'h0000);

      // R7 / R8 display handshake
      bus_write(16'hFE06, 16'h0148);
      #1 check({7'd0, disp_valid, disp_char}, 16'h0148, "R7 valid with char");
      bus_read(16'hFE04, 16'h0000, "R7 done cleared");
      bus_read(16'hFE06, 16'h0048, "R2 display char readback");
      repeat (3) @(negedge clk);
      #1 check({7'd0, disp_valid, disp_char}, 16'h0148, "R7 held while sink busy");
      sink_take();
      #1 check({15'd0, disp_valid}, 16'd0, "R8 valid drops after accept");
      bus_read(16'hFE04, 16'h8000, "R8 done set");

      // R9 display interrupt
      bus_write(16'hFE04, 16'h4000);
      #1 check({15'd0, disp_irq}, 16'd1, "R9 disp_irq high");
      bus_write(16'hFE06, 16'h0049);
      #1 check({15'd0, disp_irq}, 16'd0, "R9 disp_irq low while busy");
      sink_take();
      #1 check({15'd0, disp_irq}, 16'd1, "R9 disp_irq back after accept");
      bus_write(16'hFE04, 16'h0000);

      // R10 run latch
      bus_write(16'hFFFE, 16'h0000);
      #1 check({15'd0, run_en}, 16'd0, "R10 run cleared");
      bus_read(16'hFFFE, 16'h0000, "R10 latch readback");
      bus_write(16'hFFFE, 16'hFFFF);
      #1 check({15'd0, run_en}, 16'd1, "R10 run set");
      bus_read(16'hFFFE, 16'h8000, "R2 control layout");

      // R11 window decode
      @(negedge clk);
      bus_addr = 16'hFE00; #1 check({15'd0, bus_hit}, 16'd1, "R11 hit at base");
      bus_addr = 16'hFDFF; #1 check({15'd0, bus_hit}, 16'd0, "R11 miss below base");
      bus_addr = 16'hFFFF; #1 check({15'd0, bus_hit}, 16'd1, "R11 hit at top");
      bus_addr = 16'h3000; #1 check({15'd0, bus_hit}, 16'd0, "R11 miss in user area");
      bus_rd = 1'b1;       #1 check(bus_rdata, 16'h0000, "R2 read outside window");
      bus_rd = 1'b0;

      // R1 reset in mid-run
      bus_write(16'hFE00, 16'h4000);
      send_key(8'h50);
      bus_write(16'hFE06, 16'h0051);
      bus_write(16'hFFFE, 16'h0000);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1 check({13'd0, run_en, disp_valid, kbd_irq}, 16'h0004, "R1 outputs after reset");
      bus_read(16'hFE00, 16'h0000, "R1 keyboard status after reset");
      bus_read(16'hFE04, 16'h8000, "R1 display status after reset");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule